// File: doc/BRIEF.md
# AX.25 Frame Assembler with Frame Check Sequence

This block builds the body of an outgoing AX.25 frame one byte at a time and keeps a running 16-bit frame check sequence (FCS) over it. A controller opens a frame with a start command. It then supplies address fields as a callsign, a station identifier (SSID) and a last-address marker, and supplies payload bytes with a valid strobe. A finish command closes the frame. The assembled bytes leave on a valid/ready byte stream, ready for a downstream HDLC framer that adds flags, bit stuffing and line coding.

The FCS is the reflected CRC-16 with polynomial 0x8408 and a start value of 0xFFFF. It is sent complemented, low byte first. The frame length is limited to a parameter, 330 bytes by default. Payload and address bytes are accepted only while four bytes of room remain, so the two FCS bytes always fit. Bytes that arrive beyond that limit are dropped and a sticky overflow flag is raised.

A second instance of the same CRC step runs over a received byte stream. At the end of a frame it reports whether the residue and the length make the frame acceptable.

Top module: `ax25fb_frame_builder`

## Requirements
- R1: A start command sets the FCS to 0xFFFF, the length to 0, and clears overflow, frame-ready and any pending output byte. It also opens a frame. Start takes priority over every other command in the same cycle.
- R2: A data byte taken while the frame is open leaves unchanged on the output stream, in order. It advances the length by one and folds into the FCS.
- R3: A data or address byte is taken into the frame only while the length is below MAX_LEN-4. Otherwise the byte is discarded, nothing is emitted, and the overflow flag is set. The flag stays set until the next start.
- R4: A finish command emits the complement of FCS bits 7:0, then the complement of bits 15:8. It adds 2 to the length and then raises frame-ready. The FCS uses the reflected CRC-16, polynomial 0x8408, starting from 0xFFFF.
- R5: An address command emits six callsign bytes, each shifted left by one bit. Character 0 is taken from call_i[47:40] and later characters from lower bytes. Positions at or beyond call_len_i become 0x40, which is a space shifted left by one. A call_len_i above 6 counts as 6.
- R6: The seventh byte of an address command is 0x60, with the SSID in bits 4:1 and bit 0 set when last_addr_i was high.
- R7: An output byte is consumed only on a cycle where out_valid_o and out_ready_i are both high. While it waits, the byte holds stable.
- R8: The receive check restarts on rx_start_i and folds in every byte that has rx_valid_i. One cycle after rx_end_i it pulses rx_done_o. rx_good_o is high when the running FCS equals 0xF0B8 and at least 17 bytes were seen; it holds until the next end or restart.
- R9: When commands arrive together in the same cycle, the address command is taken before a data byte, and a data byte before finish. A command not taken stays pending.
- R10: in_ready_o is low before the first start, while address or FCS bytes are being emitted, and after finish. Commands presented while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Open a new frame |
| data_valid_i | input | 1 | Data byte command |
| data_i | input | 8 | Data byte |
| addr_valid_i | input | 1 | Address command |
| call_i | input | 48 | Callsign, character 0 in bits 47:40 |
| call_len_i | input | 3 | Number of callsign characters used |
| ssid_i | input | 4 | Station identifier |
| last_addr_i | input | 1 | Marks the last address of the header |
| finish_i | input | 1 | Close the frame and append the FCS |
| in_ready_o | output | 1 | A command is taken this cycle if one is presented |
| out_valid_o | output | 1 | Output byte valid |
| out_byte_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| len_o | output | 9 | Bytes in the frame so far |
| overflow_o | output | 1 | A byte was dropped by the length guard |
| frame_ready_o | output | 1 | Frame complete including the FCS |
| rx_start_i | input | 1 | Restart the receive check |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_end_i | input | 1 | End of received frame |
| rx_done_o | output | 1 | One-cycle result strobe |
| rx_good_o | output | 1 | Received frame passed the check |

## Verification
The properties assume that a command is held until in_ready_o takes it, and that rx_end_i never arrives together with rx_start_i. The bench's driving tasks keep to both: each command stays up until a cycle where in_ready_o was seen high. The downstream ready is randomised independently of the commands, so some commands are taken while the output byte is stalled. Random callsigns, lengths above six, SSIDs and payload sizes, together with a long frame that crosses the length guard, keep the FCS model and the formatting under constant comparison.

// File: rtl/ax25fb_pkg.sv
package ax25fb_pkg;
    localparam int unsigned MAX_LEN_DEF  = 330;
    localparam int unsigned CALL_CHARS   = 6;
    localparam int unsigned MIN_FRAME    = 17;
    localparam logic [15:0] FCS_SEED     = 16'hFFFF;
    localparam logic [15:0] FCS_RESIDUE  = 16'hF0B8;
    localparam logic [7:0]  SSID_BASE    = 8'h60;
    localparam logic [7:0]  PAD_CHAR     = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_ADDR,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_DONE
    } fb_state_e;
endpackage

// File: rtl/ax25fb_crc_step.sv
module ax25fb_crc_step (
    input  logic [15:0] fcs_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] fcs_o
);
    logic [7:0] mix;
    logic [7:0] fold;

    always_comb begin
        mix   = fcs_i[7:0] ^ byte_i;
        fold  = mix ^ {mix[3:0], 4'b0000};
        fcs_o = {8'h00, fcs_i[15:8]}
              ^ {fold, 8'h00}
              ^ {5'b00000, fold, 3'b000}
              ^ {12'h000, fold[7:4]};
    end
endmodule

// File: rtl/ax25fb_addr_fmt.sv
module ax25fb_addr_fmt
    import ax25fb_pkg::*;
#(
    parameter int unsigned CHARS = CALL_CHARS,
    parameter int unsigned IDX_W = $clog2(CHARS + 2)
) (
    input  logic [8*CHARS-1:0] call_i,
    input  logic [IDX_W-1:0]   clen_i,
    input  logic [3:0]         ssid_i,
    input  logic               last_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [7:0]         byte_o
);
    logic [7:0] slot [CHARS+1];

    for (genvar g = 0; g < CHARS; g++) begin : g_char
        assign slot[g] = (IDX_W'(g) < clen_i)
                       ? {call_i[8*(CHARS-g)-2 -: 7], 1'b0}
                       : {PAD_CHAR[6:0], 1'b0};
    end
    assign slot[CHARS] = SSID_BASE | {3'b000, ssid_i, last_i};

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i <= CHARS; i++) begin
            if (idx_i == IDX_W'(i)) byte_o = slot[i];
        end
    end
endmodule

// File: rtl/ax25fb_rx_check.sv
module ax25fb_rx_check
    import ax25fb_pkg::*;
#(
    parameter int unsigned MIN_LEN = MIN_FRAME,
    parameter int unsigned CNT_W   = $clog2(MIN_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_start_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_end_i,
    output logic       rx_done_o,
    output logic       rx_good_o
);
    typedef struct packed {
        logic [15:0]      fcs;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             good;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic [15:0]      fcs_step;
    logic [15:0]      fcs_t;
    logic [CNT_W-1:0] cnt_t;

    ax25fb_crc_step crc_i (.fcs_i(r_q.fcs), .byte_i(rx_data_i), .fcs_o(fcs_step));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fcs_t    = r_q.fcs;
        cnt_t    = r_q.cnt;
        if (rx_start_i) begin
            r_d.fcs  = FCS_SEED;
            r_d.cnt  = '0;
            r_d.good = 1'b0;
        end else begin
            if (rx_valid_i) begin
                fcs_t = fcs_step;
                if (r_q.cnt != CNT_W'(MIN_LEN)) cnt_t = r_q.cnt + 1'b1;
            end
            r_d.fcs = fcs_t;
            r_d.cnt = cnt_t;
            if (rx_end_i) begin
                r_d.done = 1'b1;
                r_d.good = (fcs_t == FCS_RESIDUE) && (cnt_t == CNT_W'(MIN_LEN));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{fcs: FCS_SEED, cnt: '0, done: 1'b0, good: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_done_o = r_q.done;
    assign rx_good_o = r_q.good;
endmodule

// File: rtl/ax25fb_frame_builder.sv
module ax25fb_frame_builder
    import ax25fb_pkg::*;
#(
    parameter int unsigned MAX_LEN = MAX_LEN_DEF,
    parameter int unsigned CHARS   = CALL_CHARS,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
    localparam int unsigned IDX_W  = $clog2(CHARS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               data_valid_i,
    input  logic [7:0]         data_i,
    input  logic               addr_valid_i,
    input  logic [8*CHARS-1:0] call_i,
    input  logic [IDX_W-1:0]   call_len_i,
    input  logic [3:0]         ssid_i,
    input  logic               last_addr_i,
    input  logic               finish_i,
    output logic               in_ready_o,
    output logic               out_valid_o,
    output logic [7:0]         out_byte_o,
    input  logic               out_ready_i,
    output logic [LEN_W-1:0]   len_o,
    output logic               overflow_o,
    output logic               frame_ready_o,
    input  logic               rx_start_i,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_data_i,
    input  logic               rx_end_i,
    output logic               rx_done_o,
    output logic               rx_good_o
);
    localparam logic [LEN_W-1:0] GUARD   = LEN_W'(MAX_LEN - 4);
    localparam logic [IDX_W-1:0] SSID_IX = IDX_W'(CHARS);

    typedef struct packed {
        fb_state_e          state;
        logic [15:0]        fcs;
        logic [LEN_W-1:0]   len;
        logic               ovf;
        logic               out_v;
        logic [7:0]         out_b;
        logic [IDX_W-1:0]   idx;
        logic [8*CHARS-1:0] call;
        logic [IDX_W-1:0]   clen;
        logic [3:0]         ssid;
        logic               last;
    } fb_regs_t;

    fb_regs_t    r_d, r_q;
    logic        slot_free;
    logic        take;
    logic [7:0]  addr_byte;
    logic [7:0]  sel_byte;
    logic [15:0] fcs_step;

    ax25fb_addr_fmt #(.CHARS(CHARS), .IDX_W(IDX_W)) fmt_i (
        .call_i (r_q.call),
        .clen_i (r_q.clen),
        .ssid_i (r_q.ssid),
        .last_i (r_q.last),
        .idx_i  (r_q.idx),
        .byte_o (addr_byte)
    );

    assign sel_byte = (r_q.state == ST_ADDR) ? addr_byte : data_i;

    ax25fb_crc_step crc_i (.fcs_i(r_q.fcs), .byte_i(sel_byte), .fcs_o(fcs_step));

    assign slot_free = !r_q.out_v || out_ready_i;

    always_comb begin
        r_d  = r_q;
        take = 1'b0;
        if (r_q.out_v && out_ready_i) r_d.out_v = 1'b0;
        if (start_i) begin
            r_d.state = ST_OPEN;
            r_d.fcs   = FCS_SEED;
            r_d.len   = '0;
            r_d.ovf   = 1'b0;
            r_d.out_v = 1'b0;
            r_d.idx   = '0;
        end else begin
            unique case (r_q.state)
                ST_OPEN: begin
                    if (slot_free) begin
                        if (addr_valid_i) begin
                            r_d.call  = call_i;
                            r_d.clen  = call_len_i;
                            r_d.ssid  = ssid_i;
                            r_d.last  = last_addr_i;
                            r_d.idx   = '0;
                            r_d.state = ST_ADDR;
                        end else if (data_valid_i) begin
                            take = 1'b1;
                        end else if (finish_i) begin
                            r_d.state = ST_FCS_LO;
                        end
                    end
                end
                ST_ADDR: begin
                    if (slot_free) begin
                        take = 1'b1;
                        if (r_q.idx == SSID_IX) begin
                            r_d.state = ST_OPEN;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                ST_FCS_LO: begin
                    if (slot_free) begin
                        r_d.out_b = ~r_q.fcs[7:0];
                        r_d.out_v = 1'b1;
                        r_d.len   = r_q.len + 1'b1;
                        r_d.state = ST_FCS_HI;
                    end
                end
                ST_FCS_HI: begin
                    if (slot_free) begin
                        r_d.out_b = ~r_q.fcs[15:8];
                        r_d.out_v = 1'b1;
                        r_d.len   = r_q.len + 1'b1;
                        r_d.state = ST_DONE;
                    end
                end
                default: begin
                end
            endcase
            if (take) begin
                if (r_q.len < GUARD) begin
                    r_d.out_b = sel_byte;
                    r_d.out_v = 1'b1;
                    r_d.fcs   = fcs_step;
                    r_d.len   = r_q.len + 1'b1;
                end else begin
                    r_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, fcs: FCS_SEED, len: '0, ovf: 1'b0,
                     out_v: 1'b0, out_b: 8'h00, idx: '0, call: '0,
                     clen: '0, ssid: 4'h0, last: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    ax25fb_rx_check rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start_i (rx_start_i),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .rx_end_i   (rx_end_i),
        .rx_done_o  (rx_done_o),
        .rx_good_o  (rx_good_o)
    );

    assign in_ready_o    = (r_q.state == ST_OPEN) && slot_free;
    assign out_valid_o   = r_q.out_v;
    assign out_byte_o    = r_q.out_b;
    assign len_o         = r_q.len;
    assign overflow_o    = r_q.ovf;
    assign frame_ready_o = (r_q.state == ST_DONE);
endmodule

// File: rtl/ax25fb_checker.sv
module ax25fb_checker
    import ax25fb_pkg::*;
#(
    parameter int unsigned MAX_LEN = MAX_LEN_DEF,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             data_valid_i,
    input logic             addr_valid_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic [7:0]       out_byte_o,
    input logic             out_ready_i,
    input logic [LEN_W-1:0] len_o,
    input logic             overflow_o,
    input logic             frame_ready_o,
    input logic             rx_start_i,
    input logic             rx_end_i,
    input logic             rx_done_o
);
    localparam logic [LEN_W-1:0] GUARD = LEN_W'(MAX_LEN - 4);

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (len_o == '0) && !overflow_o && !frame_ready_o && !out_valid_o);

    assert_len_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (len_o == $past(len_o)) || (len_o == $past(len_o) + 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid_i && !addr_valid_i && in_ready_o && !start_i && len_o >= GUARD)
        |=> overflow_o && (len_o == $past(len_o)));

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        len_o <= LEN_W'(MAX_LEN));

    assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready_o && !start_i) |=> frame_ready_o);

    assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !start_i) |=> out_valid_o && $stable(out_byte_o));

    assert_rx_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end_i && !rx_start_i) |=> rx_done_o);

    assert_rx_done_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> $past(rx_end_i));

    assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !start_i) |=> overflow_o);
endmodule

bind ax25fb_frame_builder ax25fb_checker chk_i (.*);

// File: tb/ax25fb_frame_builder_tb_top.sv
module ax25fb_frame_builder_tb_top;
    localparam int MAX_LEN = 330;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, data_valid_i = 0, addr_valid_i = 0, last_addr_i = 0, finish_i = 0;
    logic [7:0]  data_i = 0;
    logic [47:0] call_i = 0;
    logic [2:0]  call_len_i = 0;
    logic [3:0]  ssid_i = 0;
    logic        out_ready_i = 1'b1;
    logic        rx_start_i = 0, rx_valid_i = 0, rx_end_i = 0;
    logic [7:0]  rx_data_i = 0;
    logic        in_ready_o, out_valid_o, overflow_o, frame_ready_o, rx_done_o, rx_good_o;
    logic [7:0]  out_byte_o;
    logic [8:0]  len_o;

    int checks = 0;
    int errors = 0;
    bit rdy_rand = 0;
    logic [7:0]  got_q[$];
    logic [7:0]  exp_q[$];
    logic [15:0] m_fcs;
    int          m_len;
    bit          m_ovf;

    always #10 clk = ~clk;

    ax25fb_frame_builder dut_i (.*);

    always @(negedge clk) if (out_valid_o && out_ready_i) got_q.push_back(out_byte_o);

    initial forever begin
        @(posedge clk); #1;
        out_ready_i = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    function automatic logic [15:0] crc_ref(logic [15:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return c;
    endfunction

    function automatic logic [7:0] addr_ref(logic [47:0] c, int n, logic [3:0] s, logic l, int idx);
        if (idx == 6) return 8'h60 | {3'b0, s, l};
        if (idx < n) return {c[46 - 8*idx -: 7], 1'b0};
        return 8'h40;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic m_push(logic [7:0] b);
        if (m_len < MAX_LEN - 4) begin
            exp_q.push_back(b); m_fcs = crc_ref(m_fcs, b); m_len++;
        end else m_ovf = 1;
    endtask

    task automatic wait_accept();
        do @(negedge clk); while (!in_ready_o);
        tick();
    endtask

    task automatic do_start();
        start_i = 1; tick(); start_i = 0;
        got_q.delete(); exp_q.delete(); m_fcs = 16'hFFFF; m_len = 0; m_ovf = 0;
    endtask

    task automatic send_data(logic [7:0] b);
        data_i = b; data_valid_i = 1; wait_accept(); data_valid_i = 0; m_push(b);
    endtask

    task automatic send_addr(logic [47:0] c, int n, logic [3:0] s, logic l);
        call_i = c; call_len_i = 3'(n); ssid_i = s; last_addr_i = l; addr_valid_i = 1;
        wait_accept(); addr_valid_i = 0;
        for (int i = 0; i <= 6; i++) m_push(addr_ref(c, (n > 6) ? 6 : n, s, l, i));
    endtask

    task automatic do_finish();
        finish_i = 1; wait_accept(); finish_i = 0;
        exp_q.push_back(~m_fcs[7:0]); exp_q.push_back(~m_fcs[15:8]); m_len += 2;
        do @(negedge clk); while (!(frame_ready_o && !out_valid_o));
        tick();
    endtask

    task automatic check_frame(string req);
        bit same = (got_q.size() == exp_q.size());
        int bad = -1;
        if (same) foreach (got_q[i]) if (got_q[i] !== exp_q[i] && bad < 0) bad = i;
        check(same && bad < 0, req, same ? ((bad < 0) ? 0 : got_q[bad]) : got_q.size(),
              same ? ((bad < 0) ? 0 : exp_q[bad]) : exp_q.size());
        @(negedge clk);
        check(len_o == 9'(m_len), req, len_o, m_len);
        check(overflow_o == m_ovf, req, overflow_o, m_ovf);
        tick();
    endtask

    task automatic rx_feed(logic [7:0] q[$], bit exp_good, string req);
        rx_start_i = 1; tick(); rx_start_i = 0;
        foreach (q[i]) begin rx_valid_i = 1; rx_data_i = q[i]; tick(); end
        rx_valid_i = 0; rx_end_i = 1; tick(); rx_end_i = 0;
        @(negedge clk);
        check(rx_done_o == 1'b1, req, rx_done_o, 1);
        check(rx_good_o == exp_good, req, rx_good_o, exp_good);
        tick();
    endtask

    function automatic logic [47:0] rand_call();
        logic [47:0] c;
        for (int i = 0; i < 6; i++) c[8*i +: 8] = 8'h41 + 8'($urandom_range(0, 25));
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] tmp[$];
        void'($urandom(32'd4021));
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(!out_valid_o && len_o == 0 && !overflow_o && !frame_ready_o, "R1 reset", len_o, 0);
        check(!in_ready_o && !rx_good_o, "R10 reset", in_ready_o, 0);
        tick();

        // R10: a data byte before the first start is ignored
        data_i = 8'h99; data_valid_i = 1; repeat (4) tick(); data_valid_i = 0;
        @(negedge clk);
        check(got_q.size() == 0 && len_o == 0, "R10 pre-start", got_q.size(), 0);
        tick();

        // Directed frame: R2 R4 R5 R6
        do_start();
        send_addr({"N","O","C","A","L","L"}, 6, 4'h0, 1'b0);
        send_addr({"A","B","X","X","X","X"}, 2, 4'hF, 1'b1);
        send_data(8'h03); send_data(8'hF0); send_data(8'h7E); send_data(8'hC0);
        do_finish();
        check_frame("R5 R6 R2 R4 directed");
        rx_feed(got_q, 1'b1, "R8 good frame");
        tmp = got_q; tmp[5] ^= 8'h10;
        rx_feed(tmp, 1'b0, "R8 corrupted frame");

        // Random frames with a stalling downstream: R2 R4 R5 R6 R7
        rdy_rand = 1;
        for (int f = 0; f < 6; f++) begin
            do_start();
            send_addr(rand_call(), $urandom_range(0, 7), 4'($urandom), 1'b0);
            send_addr(rand_call(), $urandom_range(0, 7), 4'($urandom), 1'b1);
            for (int k = $urandom_range(0, 40); k > 0; k--) send_data(8'($urandom));
            do_finish();
            check_frame("R7 R2 R4 random");
            rx_feed(got_q, 1'b1, "R8 random frame");
        end
        rdy_rand = 0;

        // R8 length boundary: 15 data + FCS = 17 good, 14 data + FCS = 16 bad
        do_start();
        for (int k = 0; k < 15; k++) send_data(8'($urandom));
        do_finish();
        check_frame("R4 short frame");
        rx_feed(got_q, 1'b1, "R8 seventeen bytes");
        do_start();
        for (int k = 0; k < 14; k++) send_data(8'($urandom));
        do_finish();
        rx_feed(got_q, 1'b0, "R8 sixteen bytes");

        // R3 guard: 330 data bytes, only 326 taken, FCS still fits
        rdy_rand = 1;
        do_start();
        for (int k = 0; k < MAX_LEN; k++) send_data(8'($urandom));
        @(negedge clk);
        check(overflow_o == 1'b1 && len_o == 9'(MAX_LEN - 4), "R3 guard", len_o, MAX_LEN - 4);
        tick();
        do_finish();
        check_frame("R3 overflow frame");
        rdy_rand = 0;

        // R10 after finish: commands are ignored
        check(!in_ready_o, "R10 after finish", in_ready_o, 0);
        data_valid_i = 1; repeat (3) tick(); data_valid_i = 0;
        @(negedge clk);
        check(len_o == 9'(m_len) && !out_valid_o, "R10 after finish", len_o, m_len);
        tick();

        // R9 start wins over a data byte in the same cycle
        do_start();
        data_i = 8'h55; data_valid_i = 1; start_i = 1; tick(); start_i = 0; data_valid_i = 0;
        @(negedge clk);
        check(len_o == 0 && !out_valid_o, "R9 start priority", len_o, 0);
        tick();
        check(got_q.size() == 0, "R1 start priority", got_q.size(), 0);

        // R9 address before data when both are presented
        do_start();
        call_i = {"W","1","A","W","Z","Z"}; call_len_i = 3; ssid_i = 4'h7; last_addr_i = 1;
        data_i = 8'hA5; data_valid_i = 1; addr_valid_i = 1;
        wait_accept(); addr_valid_i = 0;
        for (int i = 0; i <= 6; i++) m_push(addr_ref(call_i, 3, 4'h7, 1'b1, i));
        wait_accept(); data_valid_i = 0; m_push(8'hA5);
        do_finish();
        check_frame("R9 address priority");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule